// File: doc/BRIEF.md
# Set-Associative Cache Tag Tracker

The block keeps the tag store of a set-associative cache whose geometry is fixed at elaboration: 2^SET_BITS sets, WAYS lines per set and 2^BLK_BITS-byte blocks. It stores no data. It takes at most one access per cycle, made of a 64-bit byte address and an operation code. For each access it reports whether it hit, missed, or missed and displaced a valid line, and it keeps running totals of hits, misses and evictions.

Replacement is least-recently-used. Each line carries a recency stamp copied from an access timer that advances on every access the block processes. The totals depend on the operation: instruction fetches are dropped, stores are looked up exactly like loads, and a read-modify-write counts as a load followed by one more hit for the write-back half. A performance model or a trace-replay harness uses the block to get cache statistics at hardware speed.

Top module: `cache_tag_tracker`

## Requirements
- R1: The low BLK_BITS address bits are the block offset and are ignored. The next SET_BITS bits select the set. All remaining upper bits, up to bit 63, form the tag that is compared.
- R2: An access hits when a line in the selected set is valid and holds a tag equal to the address tag.
- R3: On a miss where the set still has an invalid line, the lowest-numbered invalid way takes the tag and becomes valid. The eviction flag and the eviction total stay unchanged.
- R4: On a miss where every way of the set is valid, the way with the smallest recency stamp is replaced. The eviction flag is raised and the eviction total increments.
- R5: Every processed access advances the access timer. The line that was hit or filled takes the new timer value as its stamp, so a line that was hit recently survives the next replacement in its set.
- R6: Operation code 0 (instruction fetch) is ignored. It produces no response, changes no total and changes no line state.
- R7: Operation code 2 (store) behaves exactly like operation code 1 (load).
- R8: Operation code 3 (modify) does the load lookup and adds one more hit to the hit total, whatever the outcome of the lookup.
- R9: The response flags and the updated totals appear one clock cycle after an access is accepted, together with rsp_valid_o. Back-to-back accesses are each handled in one cycle and see the state left by the access before them.
- R10: After reset all lines are invalid, the timer is zero, all totals are zero and rsp_valid_o is low.
- R11: With WAYS = 1 the block behaves as a direct-mapped cache. Every conflicting miss in a set evicts the only line of that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_op_i | input | 2 | Operation: 0 fetch, 1 load, 2 store, 3 modify |
| req_addr_i | input | ADDR_W | Byte address of the access |
| rsp_valid_o | output | 1 | Response for the access accepted one cycle earlier |
| rsp_hit_o | output | 1 | The lookup hit |
| rsp_miss_o | output | 1 | The lookup missed |
| rsp_evict_o | output | 1 | The miss displaced a valid line |
| hit_cnt_o | output | CNT_W | Running hit total |
| miss_cnt_o | output | CNT_W | Running miss total |
| evict_cnt_o | output | CNT_W | Running eviction total |

## Verification
The properties assume that req_op_i holds a defined two-bit code whenever req_valid_i is high. They also assume that the totals never wrap during a run, so each step of a total can be compared with its previous value. The stimulus always drives one of the four codes. It draws addresses from a small pool of tags per set, so hits, fills and evictions all occur often, and its runs stay far below the counter width. Directed sequences fill and overflow one set to check the recency order. They also place a high-order tag bit near bit 63.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    OP_FETCH  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_MODIFY = 2'd3
  } acc_op_e;
endpackage

// File: rtl/cache_tag_lookup.sv
module cache_tag_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 59,
  parameter int TS_W  = 32,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0][TS_W-1:0]  stamps_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o,
  output logic [WAY_W-1:0]           victim_way_o
);
  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_o && valid_i[w] && tags_i[w] == tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end

  // scan downward so the lowest invalid way wins
  always_comb begin
    free_o     = 1'b0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end

  generate
    if (WAYS == 1) begin : g_dm
      assign victim_way_o = '0;
    end else begin : g_lru
      logic [TS_W-1:0] best;
      always_comb begin
        best         = stamps_i[0];
        victim_way_o = '0;
        for (int w = 1; w < WAYS; w++) begin
          if (stamps_i[w] < best) begin // strict: ties keep the lower way
            best         = stamps_i[w];
            victim_way_o = WAY_W'(w);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cache_tag_counters.sv
module cache_tag_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             modify_i,
  input  logic             hit_i,
  input  logic             evict_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic [CNT_W-1:0] evict_cnt_o
);
  logic [CNT_W-1:0] hit_inc;
  assign hit_inc = CNT_W'(hit_i) + CNT_W'(modify_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o   <= '0;
      miss_cnt_o  <= '0;
      evict_cnt_o <= '0;
    end else if (fire_i) begin
      hit_cnt_o   <= hit_cnt_o + hit_inc;
      miss_cnt_o  <= miss_cnt_o + CNT_W'(!hit_i);
      evict_cnt_o <= evict_cnt_o + CNT_W'(evict_i);
    end
  end
endmodule

// File: rtl/cache_tag_tracker.sv
module cache_tag_tracker
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 4,
  parameter int BLK_BITS = 3,
  parameter int TS_W     = 32,
  parameter int CNT_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_evict_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  evict_cnt_o
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - BLK_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][TS_W-1:0]  stamp_q;
  logic [TS_W-1:0]                      timer_q;

  acc_op_e             op;
  logic                fire, is_mod;
  logic [SET_BITS-1:0] set_idx;
  logic [TAG_W-1:0]    tag;
  logic [TS_W-1:0]     timer_nxt;

  assign op        = acc_op_e'(req_op_i);
  assign fire      = req_valid_i && (op != OP_FETCH);
  assign is_mod    = op == OP_MODIFY;
  assign set_idx   = req_addr_i[BLK_BITS +: SET_BITS];
  assign tag       = req_addr_i[ADDR_W-1 -: TAG_W];
  assign timer_nxt = timer_q + 1'b1;

  logic             hit, free;
  logic [WAY_W-1:0] hit_way, free_way, victim_way, upd_way;
  logic             evict;

  cache_tag_lookup #(
    .WAYS(WAYS), .TAG_W(TAG_W), .TS_W(TS_W), .WAY_W(WAY_W)
  ) u_lookup (
    .valid_i     (valid_q[set_idx]),
    .tags_i      (tag_q[set_idx]),
    .stamps_i    (stamp_q[set_idx]),
    .tag_i       (tag),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .free_o      (free),
    .free_way_o  (free_way),
    .victim_way_o(victim_way)
  );

  assign evict   = !hit && !free;
  assign upd_way = hit ? hit_way : (free ? free_way : victim_way);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      stamp_q <= '0;
      timer_q <= '0;
    end else if (fire) begin
      timer_q                    <= timer_nxt;
      stamp_q[set_idx][upd_way]  <= timer_nxt;
      if (!hit) begin
        tag_q[set_idx][upd_way]   <= tag;
        valid_q[set_idx][upd_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_evict_o <= 1'b0;
    end else begin
      rsp_valid_o <= fire;
      rsp_hit_o   <= fire && hit;
      rsp_miss_o  <= fire && !hit;
      rsp_evict_o <= fire && evict;
    end
  end

  cache_tag_counters #(.CNT_W(CNT_W)) u_counters (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .modify_i   (is_mod),
    .hit_i      (hit),
    .evict_i    (evict),
    .hit_cnt_o  (hit_cnt_o),
    .miss_cnt_o (miss_cnt_o),
    .evict_cnt_o(evict_cnt_o)
  );
endmodule

// File: rtl/cache_tag_tracker_chk.sv
module cache_tag_tracker_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       req_op_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_miss_o,
  input logic             rsp_evict_o,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o,
  input logic [CNT_W-1:0] evict_cnt_o
);
  a_r9_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i && req_op_i != 2'd0));

  a_r2_hit_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o ^ rsp_miss_o));

  a_r4_evict_needs_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_evict_o |-> (rsp_valid_o && rsp_miss_o));

  a_r4_evict_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_evict_o |-> evict_cnt_o == $past(evict_cnt_o) + 1'b1);

  a_r3_fill_keeps_evict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_evict_o) |-> $stable(evict_cnt_o));

  a_r6_idle_totals_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> ($stable(hit_cnt_o) && $stable(miss_cnt_o) && $stable(evict_cnt_o)));

  a_r8_modify_extra_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && req_op_i == 2'd3) |->
      hit_cnt_o == $past(hit_cnt_o) + CNT_W'(1) + CNT_W'(rsp_hit_o));
endmodule

bind cache_tag_tracker cache_tag_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_op_i   (req_op_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_miss_o (rsp_miss_o),
  .rsp_evict_o(rsp_evict_o),
  .hit_cnt_o  (hit_cnt_o),
  .miss_cnt_o (miss_cnt_o),
  .evict_cnt_o(evict_cnt_o)
);

// File: tb/cache_tag_tracker_tb.sv
module cache_tag_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [63:0] req_addr = '0;

  logic [1:0]        rv, rh, rm, re;
  logic [1:0][31:0]  ch, cm, ce;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_tracker #(.SET_BITS(2), .WAYS(4), .BLK_BITS(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .rsp_valid_o(rv[0]), .rsp_hit_o(rh[0]),
    .rsp_miss_o(rm[0]), .rsp_evict_o(re[0]), .hit_cnt_o(ch[0]),
    .miss_cnt_o(cm[0]), .evict_cnt_o(ce[0]));

  cache_tag_tracker #(.SET_BITS(1), .WAYS(1), .BLK_BITS(1)) u_dut_dm (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .rsp_valid_o(rv[1]), .rsp_hit_o(rh[1]),
    .rsp_miss_o(rm[1]), .rsp_evict_o(re[1]), .hit_cnt_o(ch[1]),
    .miss_cnt_o(cm[1]), .evict_cnt_o(ce[1]));

  // reference model, index 0 main geometry, index 1 direct-mapped
  int          m_sb[2] = '{2, 1};
  int          m_ew[2] = '{4, 1};
  int          m_bb[2] = '{3, 1};
  bit          mv[2][4][4];
  logic [63:0] mt[2][4][4];
  int unsigned ms[2][4][4];
  int unsigned tmr[2];
  int unsigned eh[2], em[2], ee[2];
  bit [3:0]    exp_rsp[2];
  string       pend_tag[2];

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic model_access(int m, bit [1:0] op, logic [63:0] a, output bit [3:0] r);
    int s, way;
    logic [63:0] t;
    bit h;
    int unsigned best;
    r = 4'b0;
    if (op == 2'd0) return;
    s = int'((a >> m_bb[m]) & ((64'd1 << m_sb[m]) - 1));
    t = a >> (m_sb[m] + m_bb[m]);
    tmr[m]++;
    h = 0; way = -1;
    for (int w = 0; w < m_ew[m]; w++)
      if (!h && mv[m][s][w] && mt[m][s][w] == t) begin h = 1; way = w; end
    if (h) begin
      ms[m][s][way] = tmr[m];
      r = 4'b1100;
    end else begin
      for (int w = m_ew[m] - 1; w >= 0; w--) if (!mv[m][s][w]) way = w;
      r = 4'b1010;
      if (way < 0) begin
        way = 0; best = ms[m][s][0];
        for (int w = 1; w < m_ew[m]; w++)
          if (ms[m][s][w] < best) begin best = ms[m][s][w]; way = w; end
        r = 4'b1011;
        ee[m]++;
      end
      mv[m][s][way] = 1; mt[m][s][way] = t; ms[m][s][way] = tmr[m];
      em[m]++;
    end
    eh[m] += (h ? 1 : 0) + (op == 2'd3 ? 1 : 0);
  endtask

  task automatic check_one(int m);
    bit [3:0] act;
    act = {rv[m], rh[m], rm[m], re[m]};
    n_chk++;
    if (act !== exp_rsp[m]) begin
      n_fail++;
      $display("FAIL %s dut%0d rsp v/h/m/e act=%b exp=%b", pend_tag[m], m, act, exp_rsp[m]);
    end
    n_chk++;
    if (ch[m] !== eh[m] || cm[m] !== em[m] || ce[m] !== ee[m]) begin
      n_fail++;
      $display("FAIL %s dut%0d totals act=%0d/%0d/%0d exp=%0d/%0d/%0d", pend_tag[m], m,
               ch[m], cm[m], ce[m], eh[m], em[m], ee[m]);
    end
  endtask

  function automatic string auto_tag(bit [1:0] op, bit [3:0] r);
    if (op == 2'd0) return "R6";
    if (op == 2'd3) return "R8";
    if (op == 2'd2) return "R7";
    if (r[0]) return "R4";
    if (r[1]) return "R3";
    return "R2";
  endfunction

  // at a falling edge: check the previous access, then present the next
  task automatic step(bit v, bit [1:0] op, logic [63:0] a, string tg);
    @(negedge clk);
    check_one(0);
    check_one(1);
    req_valid = v; req_op = op; req_addr = a;
    for (int m = 0; m < 2; m++) begin
      if (v) model_access(m, op, a, exp_rsp[m]);
      else exp_rsp[m] = 4'b0;
      pend_tag[m] = (m == 1) ? "R11" : ((tg != "") ? tg : auto_tag(op, exp_rsp[m]));
    end
  endtask

  function automatic logic [63:0] mk(int t, int s, int o);
    return (64'(t) << 5) | (64'(s) << 3) | 64'(o);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    for (int m = 0; m < 2; m++) begin
      exp_rsp[m] = 4'b0; pend_tag[m] = "R10"; tmr[m] = 0;
      eh[m] = 0; em[m] = 0; ee[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // first step checks the reset state (R10), first access must miss
    step(1, 2'd1, mk(1, 0, 0), "R10");
    step(1, 2'd1, mk(1, 0, 7), "R1");           // offset ignored -> hit
    step(1, 2'd1, mk(1, 1, 0), "R1");           // other set -> miss
    step(1, 2'd1, mk(2, 0, 0), "R3");
    step(1, 2'd1, mk(3, 0, 0), "R3");
    step(1, 2'd1, mk(4, 0, 0), "R3");           // set 0 now full
    step(1, 2'd1, mk(1, 0, 3), "R5");           // refresh tag 1
    step(1, 2'd1, mk(5, 0, 0), "R4");           // evicts tag 2
    step(1, 2'd1, mk(2, 0, 0), "R4");           // evicts tag 3
    step(1, 2'd1, mk(1, 0, 0), "R5");           // tag 1 survived
    step(1, 2'd0, mk(9, 0, 0), "R6");           // fetch ignored
    step(1, 2'd1, mk(9, 0, 0), "R6");           // so still a miss
    step(1, 2'd2, mk(9, 0, 1), "R7");
    step(1, 2'd2, mk(12, 0, 0), "R7");
    step(1, 2'd3, mk(12, 0, 0), "R8");
    step(1, 2'd3, mk(13, 0, 0), "R8");
    step(1, 2'd1, mk(1, 2, 0), "R1");
    step(1, 2'd1, (64'd1 << 63) | mk(1, 2, 0), "R1");
    step(1, 2'd1, mk(1, 2, 0), "R1");
    step(0, 2'd1, '0, "R9");
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a;
      a = mk(int'($urandom_range(0, 5)), int'($urandom_range(0, 3)), int'($urandom_range(0, 7)));
      if ($urandom_range(0, 15) == 0) a[62] = 1'b1;
      step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), a, "");
    end
    step(0, 2'd0, '0, "R9");
    step(0, 2'd0, '0, "R9");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule